// File: doc/BRIEF.md
# Pixel Clock Frequency Monitor

This block watches a pixel clock from the side of a free-running reference clock. Software writes a window length in 40 ns units to a small register port. The block then counts the pixel clock periods that fall inside that window and returns the total on a later read. A busy flag covers the time from the write until the count is ready. The pixel domain runs a Gray-coded period counter. Its value crosses into the reference domain through a two-stage synchronizer, so every sample the reference side takes is coherent.

The same synchronized counter drives a loss detector. If the counter stops moving for a fixed number of reference cycles, the block flags the pixel clock as missing. When the auto-switch control bit is set, it also requests a switch-over to an internal oscillator.

The block reports the frequency band in two ways:
- The selected band comes either from an external strap pin or from a control register bit.
- The measured band comes from the last completed window: it says whether that measurement fell below 15 MHz.

Top module: `pclk_freq_mon`

## Requirements
- R1: After reset, register 0 reads 0, register 1 reads 0x0001 (auto-switch on, band taken from the pin, register band bit clear), register 2 reads 0 while the pin is low, and busy is low.
- R2: A nonzero write W to address 0 raises busy at the following clock edge. Busy stays high for exactly W×REF_PER_UNIT reference cycles, and the count updates in the cycle busy falls.
- R3: The count read at address 0 equals the number of pixel clock rising edges inside the window, within ±1.
- R4: A write of 0 to address 0 ends any measurement at the next edge, drops busy, and clears the count to 0.
- R5: A nonzero write to address 0 during a measurement discards it and restarts the window with the new length, timed from the new write.
- R6: The pixel counter reaches the reference domain in Gray code. Each reference cycle, the synchronized value changes in at most one bit, provided the pixel clock is slower than the reference clock.
- R7: `clk_missing` rises once MISS_LIMIT reference cycles pass with no change in the synchronized pixel counter. It falls one cycle after a change is seen.
- R8: `osc_switch_req` is high exactly when `clk_missing` is high and control bit 0 (auto-switch enable) is 1.
- R9: `band_low` (1 = low band, 5 to below 15 MHz; 0 = high band, 15 to 85 MHz) follows `band_pin` when control bit 1 is 0. It follows control bit 2 when control bit 1 is 1.
- R10: Status bit 2 (measured low band) is set by a completed window when count×5 < W×3, which is below 15 MHz in 40 ns units. It is cleared by a completed window otherwise.
- R11: The status register at address 2 holds busy in bit 0, clk_missing in bit 1, the measured low band in bit 2 and band_low in bit 3. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset, reference domain |
| pix_clk | input | 1 | Pixel clock under measurement |
| band_pin | input | 1 | Strap pin band select, 1 = low band |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| busy | output | 1 | Measurement in progress |
| clk_missing | output | 1 | Pixel clock judged absent |
| osc_switch_req | output | 1 | Request to switch to the internal oscillator |
| band_low | output | 1 | Selected frequency band, 1 = low |

## Verification
The hardest state to reach is a restart in mid-window. The bench must prove that the first window's timer and start snapshot are fully discarded. To do this, it starts a long window, waits, and writes a short one. It then checks that busy falls exactly on the short window's cycle count and that the count matches only the short window. Loss of the pixel clock is forced by having the bench generator hold the clock low. The bench then brings the clock back to check recovery, with the auto-switch bit toggled in between.

// File: rtl/pcm_pkg.sv
// Shared constants and helpers for the pixel clock frequency monitor.
// Assumes: register addresses are two bits wide.
package pcm_pkg;
    localparam logic [1:0] ADDR_WIN  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // Gray code to binary for a 16-bit or narrower value held in 32 bits.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g, input int w);
        logic [31:0] b;
        b = '0;
        for (int i = 31; i >= 0; i--) begin
            if (i < w) b[i] = ((i == w - 1) ? 1'b0 : b[i+1]) ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/pcm_pix_count.sv
// Pixel-domain free-running period counter, published in Gray code.
// Assumes: pix_clk toggles while rst_n is low, so the local reset takes effect.
module pcm_pix_count #(
    parameter int CNT_W = 16
) (
    input  logic             pix_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_q
);
    logic [1:0]       prst_q;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nx;

    assign bin_nx = bin_q + 1'b1;

    // Bring the reference reset into the pixel domain.
    always_ff @(posedge pix_clk) begin
        prst_q <= {prst_q[0], rst_n};
    end

    // Count pixel periods and register their Gray form.
    always_ff @(posedge pix_clk) begin
        if (!prst_q[1]) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/pcm_cdc_gray.sv
// Reference-domain two-flop synchronizer for the Gray counter, plus binary decode.
// Assumes: the pixel clock is slower than the reference clock.
module pcm_cdc_gray #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_q
);
    import pcm_pkg::*;
    logic [CNT_W-1:0] s1_q, s2_q;

    // Two-stage synchronizer, then registered binary decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= '0;
            s2_q  <= '0;
            bin_q <= '0;
        end else begin
            s1_q  <= gray_in;
            s2_q  <= s1_q;
            bin_q <= CNT_W'(gray_to_bin(32'(s2_q), CNT_W));
        end
    end

    // R6: the synchronized Gray word moves by at most one bit per cycle.
    a_r6_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s2_q ^ $past(s2_q)) <= 1);
endmodule

// File: rtl/pcm_window.sv
// Measurement window timer: snapshots the counter at start and end, reports the difference.
// Assumes: pix_cnt is the synchronized binary count; a start restarts any running window.
module pcm_window #(
    parameter int DATA_W       = 16,
    parameter int REF_PER_UNIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] win_len,
    input  logic [DATA_W-1:0] pix_cnt,
    output logic              busy,
    output logic [DATA_W-1:0] count_q,
    output logic              meas_low
);
    localparam int TW = DATA_W + $clog2(REF_PER_UNIT + 1);
    localparam int MW = DATA_W + 3;

    logic [TW-1:0]     timer_q;
    logic [DATA_W-1:0] start_q;
    logic [DATA_W-1:0] win_q;
    logic [DATA_W-1:0] diff;
    logic              done;
    logic              low_nx;

    assign diff   = pix_cnt - start_q;
    assign done   = busy && (timer_q == TW'(1)) && !start;
    assign low_nx = (MW'(diff) * MW'(5)) < (MW'(win_q) * MW'(3));

    // Load, run and close the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            timer_q  <= '0;
            start_q  <= '0;
            win_q    <= '0;
            count_q  <= '0;
            meas_low <= 1'b0;
        end else if (start) begin
            win_q   <= win_len;
            start_q <= pix_cnt;
            timer_q <= TW'(win_len) * TW'(REF_PER_UNIT);
            busy    <= (win_len != '0);
            if (win_len == '0) count_q <= '0;
        end else if (done) begin
            busy     <= 1'b0;
            timer_q  <= '0;
            count_q  <= diff;
            meas_low <= low_nx;
        end else if (busy) begin
            timer_q <= timer_q - 1'b1;
        end
    end

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && win_len != '0) |=> busy);
    a_r4_zero_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (start && win_len == '0) |=> (!busy && count_q == '0));
    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(count_q));
endmodule

// File: rtl/pcm_loss_det.sv
// Missing-clock detector: flags the pixel clock absent after a quiet stretch.
// Assumes: any change of the synchronized count means pixel edges arrived.
module pcm_loss_det #(
    parameter int CNT_W      = 16,
    parameter int MISS_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pix_cnt,
    output logic             missing
);
    localparam int IW = $clog2(MISS_LIMIT + 1);

    logic [CNT_W-1:0] prev_q;
    logic [IW-1:0]    idle_q;
    logic             moved;

    assign moved = (pix_cnt != prev_q);

    // Count quiet cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            idle_q  <= '0;
            missing <= 1'b0;
        end else begin
            prev_q <= pix_cnt;
            if (moved) begin
                idle_q  <= '0;
                missing <= 1'b0;
            end else if (idle_q >= IW'(MISS_LIMIT - 1)) begin
                idle_q  <= IW'(MISS_LIMIT);
                missing <= 1'b1;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    a_r7_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        moved |=> !missing);
endmodule

// File: rtl/pclk_freq_mon.sv
// Top of the pixel clock frequency monitor: register port, band select,
// window measurement and missing-clock switch-over request.
// Assumes: clk is a 25 MHz multiple matching REF_PER_UNIT for 40 ns units,
// and the pixel clock is slower than clk.
module pclk_freq_mon #(
    parameter int DATA_W       = 16,
    parameter int REF_PER_UNIT = 10,
    parameter int MISS_LIMIT   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_clk,
    input  logic              band_pin,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              busy,
    output logic              clk_missing,
    output logic              osc_switch_req,
    output logic              band_low
);
    import pcm_pkg::*;

    logic [DATA_W-1:0] gray_pix;
    logic [DATA_W-1:0] pix_cnt;
    logic [DATA_W-1:0] count;
    logic              meas_low;
    logic              ctrl_auto, ctrl_src, ctrl_band;
    logic              win_start;

    assign win_start = reg_wr && (reg_addr == ADDR_WIN);

    pcm_pix_count #(.CNT_W(DATA_W)) u_pix (
        .pix_clk(pix_clk), .rst_n(rst_n), .gray_q(gray_pix));

    pcm_cdc_gray #(.CNT_W(DATA_W)) u_cdc (
        .clk(clk), .rst_n(rst_n), .gray_in(gray_pix), .bin_q(pix_cnt));

    pcm_window #(.DATA_W(DATA_W), .REF_PER_UNIT(REF_PER_UNIT)) u_win (
        .clk(clk), .rst_n(rst_n), .start(win_start), .win_len(reg_wdata),
        .pix_cnt(pix_cnt), .busy(busy), .count_q(count), .meas_low(meas_low));

    pcm_loss_det #(.CNT_W(DATA_W), .MISS_LIMIT(MISS_LIMIT)) u_loss (
        .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .missing(clk_missing));

    // Control register: auto-switch enable, band source, register band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_auto <= 1'b1;
            ctrl_src  <= 1'b0;
            ctrl_band <= 1'b0;
        end else if (reg_wr && reg_addr == ADDR_CTRL) begin
            ctrl_auto <= reg_wdata[0];
            ctrl_src  <= reg_wdata[1];
            ctrl_band <= reg_wdata[2];
        end
    end

    // Status outputs: switch-over request and selected band.
    always_comb begin
        osc_switch_req = clk_missing && ctrl_auto;
        band_low       = ctrl_src ? ctrl_band : band_pin;
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_WIN:  reg_rdata = count;
            ADDR_CTRL: reg_rdata = DATA_W'({ctrl_band, ctrl_src, ctrl_auto});
            ADDR_STAT: reg_rdata = DATA_W'({band_low, meas_low, clk_missing, busy});
            default:   reg_rdata = '0;
        endcase
    end

    a_r8_fall_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_missing) |-> !osc_switch_req);
    a_r9_reg_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_src && $past(ctrl_src) && $stable(ctrl_band)) |-> $stable(band_low));
endmodule

// File: tb/pclk_freq_mon_tb.sv
`timescale 1ns/1ps
module pclk_freq_mon_tb;
    localparam int DW = 16;
    localparam int UNIT = 10;

    logic clk = 0, rst_n = 0, pix_clk = 0, band_pin = 0, reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [DW-1:0] reg_wdata = 0, reg_rdata;
    logic busy, clk_missing, osc_switch_req, band_low;
    int errors = 0, checks = 0;
    int pix_half = 10;
    bit pix_on = 1;

    pclk_freq_mon #(.DATA_W(DW), .REF_PER_UNIT(UNIT), .MISS_LIMIT(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .band_pin(band_pin),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy(busy), .clk_missing(clk_missing),
        .osc_switch_req(osc_switch_req), .band_low(band_low));

    always #2 clk = ~clk;

    always begin
        if (pix_on) begin
            #(pix_half) pix_clk = ~pix_clk;
        end else begin
            pix_clk = 0;
            #1;
        end
    end

    task automatic chk(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = DW'(d);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #0.1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        rd(2'd0, v); chk("R1 count", v, 0, 0);
        rd(2'd1, v); chk("R1 ctrl", v, 1, 1);
        rd(2'd2, v); chk("R1 status", v, 0, 0);
        rd(2'd3, v); chk("R11 addr3", v, 0, 0);
        chk("R1 busy", busy, 0, 0);
    endtask

    task automatic t_measure(input int half, input int w, input int exp_cnt, input int exp_low);
        int v;
        pix_half = half;
        wait_neg(20);
        wr(2'd0, w);
        chk("R2 busy rise", busy, 1, 1);
        wait_neg(w * UNIT - 1);
        chk("R2 busy held", busy, 1, 1);
        wait_neg(1);
        chk("R2 busy fall", busy, 0, 0);
        rd(2'd0, v); chk("R3 count", v, exp_cnt - 1, exp_cnt + 1);
        rd(2'd2, v); chk("R10 meas low", (v >> 2) & 1, exp_low, exp_low);
        chk("R11 status busy bit", v & 1, 0, 0);
    endtask

    task automatic t_restart;
        int v;
        pix_half = 10;
        wr(2'd0, 100);
        wait_neg(50);
        wr(2'd0, 10);
        wait_neg(10 * UNIT - 1);
        chk("R5 busy held", busy, 1, 1);
        wait_neg(1);
        chk("R5 busy fall", busy, 0, 0);
        rd(2'd0, v); chk("R5 count", v, 19, 21);
    endtask

    task automatic t_zero;
        int v;
        wr(2'd0, 50);
        wait_neg(30);
        wr(2'd0, 0);
        chk("R4 busy", busy, 0, 0);
        rd(2'd0, v); chk("R4 count", v, 0, 0);
        wait_neg(600);
        chk("R4 stays idle", busy, 0, 0);
    endtask

    task automatic t_missing;
        int v;
        pix_on = 0;
        wait_neg(100);
        chk("R7 missing", clk_missing, 1, 1);
        chk("R8 request", osc_switch_req, 1, 1);
        rd(2'd2, v); chk("R11 status missing bit", (v >> 1) & 1, 1, 1);
        wr(2'd1, 0);
        chk("R8 disabled", osc_switch_req, 0, 0);
        chk("R7 still missing", clk_missing, 1, 1);
        pix_on = 1;
        wait_neg(30);
        chk("R7 recovered", clk_missing, 0, 0);
        wr(2'd1, 1);
        chk("R8 no request", osc_switch_req, 0, 0);
    endtask

    task automatic t_band;
        int v;
        band_pin = 1; #0.1;
        chk("R9 pin low band", band_low, 1, 1);
        rd(2'd2, v); chk("R11 status band bit", (v >> 3) & 1, 1, 1);
        band_pin = 0; #0.1;
        chk("R9 pin high band", band_low, 0, 0);
        wr(2'd1, 7);
        chk("R9 reg low band", band_low, 1, 1);
        wr(2'd1, 3);
        band_pin = 1; #0.1;
        chk("R9 reg high, pin ignored", band_low, 0, 0);
        rd(2'd1, v); chk("R9 ctrl readback", v, 3, 3);
        wr(2'd1, 1);
        band_pin = 0;
    endtask

    initial begin
        wait_neg(8);
        rst_n = 1;
        wait_neg(8);
        t_reset();
        t_measure(10, 10, 20, 0);
        t_measure(50, 25, 10, 1);
        t_measure(10, 10, 20, 0);
        t_restart();
        t_zero();
        t_missing();
        t_band();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule